// File: doc/BRIEF.md
# Speculation-Aware Output Queue

This queue sits at the output of one datapath operator. It hands values to the following stage as soon as they arrive, whether they are already confirmed or still speculative, and keeps every handed-over value in storage until the stage that produced it is declared correct, so that a replay stays possible. Commit and fail tokens arrive on their own input. They are held in a token ring and matched to values purely by arrival order, never by slot position.

Each value slot belongs to one of four contiguous regions, marked by four pointers. The release pointer frees the oldest slot. The confirm boundary marks the first speculative slot, which is the slot a token acts on and the place where rewrites after a failure begin. The send pointer marks the next slot to hand on. The write pointer marks where new data lands. A commit moves the confirm boundary forward, but only after the matching value has been sent. A fail throws away the speculative slot and every younger slot, and it passes a fail pulse downstream only when a bad value has already left the queue. In input-queue mode, slots are freed once they are confirmed and sent, without waiting for a stage confirmation.

Top module: `spec_outq`

## Requirements
- R1: After reset, out_valid=0, ftok_out=0 and in_ready=1, and the queue holds neither values nor tokens.
- R2: Values leave in arrival order. out_spec=1 marks a value at or beyond the oldest unconfirmed slot. A value written with in_spec=0 while no speculative slot is outstanding is confirmed at once (out_spec=0). Written after a speculative slot, it joins the speculative region (out_spec=1).
- R3: A sent value keeps its slot until it is released. in_ready=0 once DEPTH slots are held, and in_valid is ignored while in_ready=0.
- R4: With INPUT_MODE=0, each cycle with stage_ok=1 releases the oldest slot, provided that slot is both confirmed and sent. Without stage_ok, no slot is released.
- R5: A commit token (tok_fail=0) acts on the oldest speculative slot only after that slot has been sent, and then confirms it.
- R6: A fail token (tok_fail=1) acts as soon as a speculative slot exists. It discards that slot and all younger ones, rewinds the send pointer to that slot if the pointer had passed it, and places the next written value in that slot. ftok_out=1 for that one cycle exactly when the failed slot had already been sent.
- R7: Tokens are held in order in a 2*DEPTH deep ring. A token that arrives before its value waits, so a run of 2*DEPTH alternating commit and fail tokens is kept whole.
- R8: With INPUT_MODE=1, a slot that is confirmed and sent is released on its own, and stage_ok is not used.
- R9: out_valid=0 in any cycle in which a fail token is acting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming value present |
| in_data | input | W | Incoming value |
| in_spec | input | 1 | Incoming value is speculative |
| in_ready | output | 1 | A free slot is available |
| tok_valid | input | 1 | Token present |
| tok_fail | input | 1 | 1 = fail token, 0 = commit token |
| out_valid | output | 1 | A value is ready for the successor |
| out_ready | input | 1 | Successor takes the value |
| out_data | output | W | Value offered to the successor |
| out_spec | output | 1 | Offered value is still unconfirmed |
| ftok_out | output | 1 | Fail token forwarded to the successor |
| stage_ok | input | 1 | Producing stage confirmed; release the oldest slot |

## Verification
A write, pop, token or stage confirmation takes effect on the clock edge that samples it. out_data, out_spec, out_valid and in_ready show the result half a cycle later. A token, however, only reaches its applying slot one edge after it is accepted. In that following cycle, ftok_out and the suppression of out_valid appear combinationally, the discard lands on the edge after, and in input mode the release lands one edge after the commit is applied. The bench drives inputs on falling edges and samples right after the edge that completes each effect, so every expected value is read in the cycle named above.

// File: rtl/spec_outq.sv
module spec_outq #(
  parameter int DEPTH = 16,
  parameter int W = 32,
  parameter int INPUT_MODE = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  input  logic         in_spec,
  output logic         in_ready,
  input  logic         tok_valid,
  input  logic         tok_fail,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data,
  output logic         out_spec,
  output logic         ftok_out,
  input  logic         stage_ok
);
  localparam int AW = $clog2(DEPTH);
  localparam int TD = 2 * DEPTH;
  localparam int TAW = AW + 1;
  localparam logic [AW:0] DV = DEPTH[AW:0];
  localparam logic [TAW:0] TDV = TD[TAW:0];
  localparam logic [AW:0] ONE = {{AW{1'b0}}, 1'b1};
  localparam logic [TAW:0] TONE = {{TAW{1'b0}}, 1'b1};

  logic [W-1:0] vbuf [DEPTH];
  logic [TD-1:0] tbuf;
  logic [AW:0] wr, rd, ow, sr;
  logic [TAW:0] th, tt;

  wire [AW:0] d_wr = wr - rd;
  wire [AW:0] d_ow = ow - rd;
  wire [AW:0] d_sr = sr - rd;
  wire [TAW:0] tcnt = tt - th;

  wire tok_avail    = tcnt != '0;
  wire tok_f        = tbuf[th[TAW-1:0]];
  wire fail_apply   = tok_avail && tok_f && (d_ow < d_wr);
  wire commit_apply = tok_avail && !tok_f && (d_ow < d_sr);
  wire in_fire      = in_valid && in_ready;
  wire out_fire     = out_valid && out_ready;
  wire tok_push     = tok_valid && (tcnt != TDV);
  wire release_one  = (d_ow != '0) && (d_sr != '0) && ((INPUT_MODE != 0) || stage_ok);
  wire [AW:0] base_wr = fail_apply ? ow : wr;
  wire ow_step = commit_apply || (in_fire && !in_spec && (fail_apply || ow == wr));

  assign in_ready  = d_wr != DV;
  assign out_valid = (d_sr != d_wr) && !fail_apply;
  assign out_data  = vbuf[sr[AW-1:0]];
  assign out_spec  = d_sr >= d_ow;
  assign ftok_out  = fail_apply && (d_ow < d_sr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr <= '0;
      rd <= '0;
      ow <= '0;
      sr <= '0;
      th <= '0;
      tt <= '0;
    end else begin
      wr <= in_fire ? base_wr + ONE : base_wr;
      if (ow_step) ow <= ow + ONE;
      if (fail_apply) begin
        if (d_sr > d_ow) sr <= ow;
      end else if (out_fire) begin
        sr <= sr + ONE;
      end
      if (release_one) rd <= rd + ONE;
      if (tok_push) tt <= tt + TONE;
      if (fail_apply || commit_apply) th <= th + TONE;
    end
  end

  always_ff @(posedge clk) begin
    if (in_fire) vbuf[base_wr[AW-1:0]] <= in_data;
    if (tok_push) tbuf[tt[TAW-1:0]] <= tok_fail;
  end

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (d_wr == DV) |-> !in_ready);
  a_r3_regions: assert property (@(posedge clk) disable iff (!rst_n)
    (d_ow <= d_wr) && (d_sr <= d_wr) && (d_wr <= DV));
  a_r4_hold_unconfirmed: assert property (@(posedge clk) disable iff (!rst_n)
    (INPUT_MODE == 0 && !stage_ok) |=> rd == $past(rd));
  a_r6_rewind: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_apply && !in_fire) |=> wr == $past(ow));
  a_r9_quiet_on_fail: assert property (@(posedge clk) disable iff (!rst_n)
    ftok_out |-> !out_valid);
  a_r7_token_room: assert property (@(posedge clk) disable iff (!rst_n)
    tcnt <= TDV);
endmodule

// File: tb/spec_outq_tb.sv
`timescale 1ns/1ps
module spec_outq_tb;
  localparam int D = 4;
  localparam int W = 8;
  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic in_valid = 0, in_spec = 0, tok_valid = 0, tok_fail = 0, out_ready = 0, stage_ok = 0;
  logic [W-1:0] in_data = 0;
  logic in_ready, out_valid, out_spec, ftok_out;
  logic [W-1:0] out_data;

  logic i_in_valid = 0, i_tok_valid = 0, i_out_ready = 0;
  logic [W-1:0] i_in_data = 0;
  logic i_in_ready, i_out_valid, i_out_spec, i_ftok;
  logic [W-1:0] i_out_data;

  spec_outq #(.DEPTH(D), .W(W), .INPUT_MODE(0)) u_dut (
    .clk, .rst_n, .in_valid, .in_data, .in_spec, .in_ready, .tok_valid, .tok_fail,
    .out_valid, .out_ready, .out_data, .out_spec, .ftok_out, .stage_ok);

  spec_outq #(.DEPTH(D), .W(W), .INPUT_MODE(1)) u_in (
    .clk, .rst_n, .in_valid(i_in_valid), .in_data(i_in_data), .in_spec(1'b1),
    .in_ready(i_in_ready), .tok_valid(i_tok_valid), .tok_fail(1'b0),
    .out_valid(i_out_valid), .out_ready(i_out_ready), .out_data(i_out_data),
    .out_spec(i_out_spec), .ftok_out(i_ftok), .stage_ok(1'b0));

  int tests = 0, fails = 0, cycles = 0;

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic reset_all();
    rst_n = 0; tick(); tick(); rst_n = 1; tick();
  endtask

  task automatic push(int d, bit s);
    in_valid = 1; in_data = d[W-1:0]; in_spec = s; tick(); in_valid = 0;
  endtask

  task automatic pop(string req, int d, bit s);
    chk(req, int'(out_valid), 1);
    chk(req, int'(out_data), d);
    chk(req, int'(out_spec), int'(s));
    out_ready = 1; tick(); out_ready = 0;
  endtask

  task automatic tok(bit f);
    tok_valid = 1; tok_fail = f; tick(); tok_valid = 0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++; tests++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 20000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    reset_all();
    // R1 reset state
    chk("R1 out_valid", int'(out_valid), 0);
    chk("R1 ftok_out", int'(ftok_out), 0);
    chk("R1 in_ready", int'(in_ready), 1);

    // R2 order, R3 retention/backpressure, R4 stage release
    for (int i = 1; i <= D; i++) push(i, 0);
    chk("R3 full", int'(in_ready), 0);
    push(99, 0);
    for (int i = 1; i <= D; i++) pop("R2 order", i, 0);
    chk("R3 ignored write", int'(out_valid), 0);
    chk("R3 retained", int'(in_ready), 0);
    stage_ok = 1; tick();
    chk("R4 release one", int'(in_ready), 1);
    tick(); tick(); tick(); tick();
    stage_ok = 0;
    push(5, 0);
    pop("R4 after release", 5, 0);

    // R5 commit waits for send, R6 fail on unsent slot
    reset_all();
    push(20, 1); push(21, 1);
    tok(0);
    tick();
    chk("R5 commit waits", int'(out_data), 20);
    chk("R5 still spec", int'(out_spec), 1);
    pop("R5 send", 20, 1);
    tick();
    chk("R5 next value", int'(out_data), 21);
    chk("R5 next spec", int'(out_spec), 1);
    tok(1);
    chk("R6 unsent no ftok", int'(ftok_out), 0);
    tick();
    chk("R6 discarded", int'(out_valid), 0);

    // R6 fail after send, R9
    reset_all();
    push(30, 1); push(31, 1);
    pop("R2 spec", 30, 1); pop("R2 spec", 31, 1);
    tok(1);
    chk("R6 ftok sent", int'(ftok_out), 1);
    chk("R9 gated", int'(out_valid), 0);
    tick();
    chk("R6 pulse ends", int'(ftok_out), 0);
    chk("R6 discard", int'(out_valid), 0);
    push(40, 0);
    pop("R6 overwrite", 40, 0);

    // R7 token before value
    reset_all();
    tok(1);
    chk("R7 waits", int'(ftok_out), 0);
    push(50, 1);
    chk("R7 applies", int'(out_valid), 0);
    chk("R7 no ftok", int'(ftok_out), 0);
    tick();
    push(51, 0);
    pop("R7 confirmed after", 51, 0);

    // R2 confirmed value behind speculative joins speculative
    reset_all();
    push(60, 1); push(61, 0);
    pop("R2 spec head", 60, 1);
    chk("R2 joins spec", int'(out_spec), 1);
    tok(1);
    chk("R6 ftok", int'(ftok_out), 1);
    tick();
    chk("R6 both gone", int'(out_valid), 0);

    // R7 alternating tokens, 2*D deep
    reset_all();
    for (int k = 0; k < D; k++) begin tok(0); tok(1); end
    stage_ok = 1;
    for (int k = 0; k < D; k++) begin
      push(100 + 2 * k, 1);
      pop("R7 alt commit", 100 + 2 * k, 1);
      tick();
      push(101 + 2 * k, 1);
      chk("R7 alt fail", int'(out_valid), 0);
      tick();
    end
    push(200, 1);
    tick(); tick();
    chk("R7 tokens drained", int'(out_valid), 1);
    chk("R7 tokens drained data", int'(out_data), 200);
    stage_ok = 0;

    // R8 input mode
    reset_all();
    for (int i = 1; i <= D; i++) begin
      i_in_valid = 1; i_in_data = W'(i); tick(); i_in_valid = 0;
    end
    chk("R8 full", int'(i_in_ready), 0);
    for (int i = 1; i <= D; i++) begin
      chk("R8 order", int'(i_out_data), i);
      i_out_ready = 1; tick(); i_out_ready = 0;
    end
    chk("R8 held", int'(i_in_ready), 0);
    i_tok_valid = 1; tick(); i_tok_valid = 0;
    tick(); tick();
    chk("R8 freed on commit", int'(i_in_ready), 1);
    chk("R8 no ftok", int'(i_ftok), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule